// File: doc/BRIEF.md
# Differential Timestamp Generator

This block measures the time that has passed since the last timestamp was handed to a trace packetizer, and asks that packetizer to emit a new relative timestamp whenever one is worth sending. Time is counted in prescaled ticks. A 2-bit select picks a tick rate of one tick per 1, 4, 16 or 64 clock cycles. An elapsed counter advances on each tick. A second counter measures how many ticks have passed since the last packet write or the last accepted timestamp.

A request is raised in three cases. The first is a packet write that finds the elapsed counter non-zero. The second is the elapsed counter wrapping past its maximum. The third is a quiet stretch of `IDLE_TICKS` ticks. Each request is offered on a valid/ready port with the elapsed count and a 2-bit reason. Only one request can be outstanding at a time. Acceptance restarts the measurement. Clearing the enable stops everything and withdraws any request.

The controller is a three-state machine:
- `ST_OFF`: disabled, everything held clear.
- `ST_RUN`: counting and watching for events.
- `ST_HOLD`: a request is offered.

The transitions are:
- OFF→RUN when the enable is seen set. That edge is an arming cycle in which nothing counts.
- RUN→HOLD on an overflow, a packet or an idle event.
- HOLD→RUN on acceptance.
- Any state→OFF while the enable is clear.

Top module: `delta_ts_gen`

## Requirements
- R1: After reset, and in every cycle that follows an edge where `ts_en` was low, `ts_valid` is 0.
- R2: `ps_sel` sets the tick period: 00 = every cycle, 01 = every 4 cycles, 10 = every 16 cycles, 11 = every 64 cycles. The cycle divider restarts from zero when disabled and after each tick. A tick fires as soon as the divider is at or above the period minus one, so a smaller period chosen mid-stream takes effect at once.
- R3: In `ST_RUN`, a `pkt_wr` pulse while the elapsed count is non-zero raises a request with reason 00 in the next cycle. The request carries the count held at the write edge.
- R4: In `ST_RUN`, a `pkt_wr` pulse while the elapsed count is zero raises no request. In every state, a `pkt_wr` pulse restarts the idle measure.
- R5: In `ST_RUN`, a tick that finds the count at its all-ones maximum raises a request with reason 01 and count equal to the maximum, and the counter wraps to zero.
- R6: In `ST_RUN`, once `IDLE_TICKS` ticks have passed since the last packet write or acceptance, a request with reason 10 is raised carrying the current count.
- R7: When several events coincide in one cycle, overflow wins over packet, and packet wins over idle.
- R8: An offered request keeps `ts_count` and `ts_reason` unchanged until `ts_ready` is high. Events during `ST_HOLD` raise no further request. During `ST_HOLD` the counter stops at its maximum instead of wrapping.
- R9: Acceptance (`ts_valid` and `ts_ready` high at an edge) clears both the elapsed count and the idle measure.
- R10: A low `ts_en` at an edge withdraws any request and clears the counters and divider. The first edge with `ts_en` high again only arms the block, and counting starts at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ts_en | input | 1 | Timestamp generation enable |
| ps_sel | input | SEL_W | Tick prescale select (power of four) |
| pkt_wr | input | 1 | One-cycle pulse per trace packet written to the output FIFO |
| ts_ready | input | 1 | Packetizer accepts the offered timestamp |
| ts_valid | output | 1 | Timestamp request offered |
| ts_count | output | CNT_W | Elapsed ticks carried by the request |
| ts_reason | output | 2 | 00 packet, 01 overflow, 10 idle |

## Verification
The bench builds two copies of the block with a 6-bit counter, so the counter wraps after 64 ticks. One copy has an idle limit of 12 ticks, which makes idle requests frequent. The other has an idle limit of 100 ticks, which lies above the wrap point, so overflow requests, the saturation in the hold state and overflow-versus-packet collisions can be reached in a few thousand cycles. Both copies share one stimulus stream and are compared on every clock against a behavioural model. The stream covers all four prescale codes, mid-stream prescale changes, back-pressure and enable drops with a request outstanding.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RUN  = 2'b01,
        ST_HOLD = 2'b10
    } dts_state_e;

    typedef enum logic [1:0] {
        RSN_PKT  = 2'b00,
        RSN_OVF  = 2'b01,
        RSN_IDLE = 2'b10
    } dts_reason_e;

endpackage

// File: rtl/dts_prescaler.sv
module dts_prescaler #(
    parameter int SEL_W    = 2,
    parameter int STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int DIV_W = STEP_LOG * (NSEL - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim_m1 [NSEL];

    // period-minus-one per select code: 4^code - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_m1[g] = DIV_W'((1 << (STEP_LOG * g)) - 1);
    end

    assign tick = active && (div_q >= lim_m1[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               div_q <= '0;
        else if (!active || tick) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    // R2: after a tick the divider restarts, so only the 1-cycle period ticks back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sel == '0 || !tick));

    // R2 / R10: an inactive cycle leaves the divider at zero
    a_r2_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (div_q == '0));

endmodule

// File: rtl/dts_counters.sv
module dts_counters #(
    parameter int CNT_W      = 21,
    parameter int IDLE_TICKS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             wrap_ok,
    input  logic             pkt,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_max,
    output logic             idle_hit
);
    localparam int IW = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [IW-1:0] idle_q;

    assign cnt_max  = (cnt == MAXV);
    assign idle_hit = (idle_q == IW'(IDLE_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick) begin
            if (cnt_max)  cnt <= wrap_ok ? '0 : MAXV;
            else          cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idle_q <= '0;
        else if (clr || pkt)         idle_q <= '0;
        else if (tick && !idle_hit)  idle_q <= idle_q + 1'b1;
    end

    // R9: a clear leaves both measures at zero
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && idle_q == '0));

    // R5: a tick at the maximum in the run state wraps to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap_ok && !clr && cnt == MAXV) |=> (cnt == '0));

    // R8: while a request is held the counter sticks at the maximum
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap_ok && !clr && cnt == MAXV) |=> (cnt == MAXV));

endmodule

// File: rtl/delta_ts_gen.sv
module delta_ts_gen #(
    parameter int CNT_W      = 21,
    parameter int IDLE_TICKS = 1024,
    parameter int SEL_W      = 2,
    parameter int STEP_LOG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_en,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             pkt_wr,
    input  logic             ts_ready,
    output logic             ts_valid,
    output logic [CNT_W-1:0] ts_count,
    output logic [1:0]       ts_reason
);
    import dts_pkg::*;

    localparam logic [CNT_W-1:0] MAXV = '1;

    dts_state_e       state_q, state_d;
    dts_reason_e      rsn_q, rsn_d;
    logic [CNT_W-1:0] pay_q;
    logic             active, tick, clr, accept;
    logic [CNT_W-1:0] cnt;
    logic             cnt_max, idle_hit;
    logic             ovf_ev, pkt_ev, idle_ev, req_any;

    assign active  = ts_en && (state_q != ST_OFF);
    assign accept  = (state_q == ST_HOLD) && ts_ready;
    assign clr     = !ts_en || accept;
    assign ovf_ev  = (state_q == ST_RUN) && tick && cnt_max;
    assign pkt_ev  = (state_q == ST_RUN) && pkt_wr && (cnt != '0);
    assign idle_ev = (state_q == ST_RUN) && idle_hit;
    assign req_any = ovf_ev || pkt_ev || idle_ev;

    dts_prescaler #(.SEL_W(SEL_W), .STEP_LOG(STEP_LOG)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .sel    (ps_sel),
        .tick   (tick)
    );

    dts_counters #(.CNT_W(CNT_W), .IDLE_TICKS(IDLE_TICKS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick),
        .wrap_ok  (state_q == ST_RUN),
        .pkt      (pkt_wr),
        .cnt      (cnt),
        .cnt_max  (cnt_max),
        .idle_hit (idle_hit)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (ts_en) state_d = ST_RUN;
            ST_RUN:  if (!ts_en) state_d = ST_OFF;
                     else if (req_any) state_d = ST_HOLD;
            ST_HOLD: if (!ts_en) state_d = ST_OFF;
                     else if (ts_ready) state_d = ST_RUN;
            default: state_d = ST_OFF;
        endcase
    end

    // reason priority: overflow, then packet, then idle
    always_comb begin
        if (ovf_ev)      rsn_d = RSN_OVF;
        else if (pkt_ev) rsn_d = RSN_PKT;
        else             rsn_d = RSN_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q <= '0;
            rsn_q <= RSN_PKT;
        end else if (ts_en && req_any) begin
            pay_q <= ovf_ev ? MAXV : cnt;
            rsn_q <= rsn_d;
        end
    end

    always_comb begin
        ts_valid  = (state_q == ST_HOLD);
        ts_count  = pay_q;
        ts_reason = rsn_q;
    end

    // R8: an unaccepted request stays put
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !ts_ready && ts_en) |=> (ts_valid && $stable(ts_count) && $stable(ts_reason)));

    // R10: disabling withdraws the request
    a_r10_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_en |=> !ts_valid);

    // R4: a packet at zero count raises nothing
    a_r4_zero_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ts_en && pkt_wr && cnt == '0 && !ovf_ev && !idle_ev) |=> !ts_valid);

    // R3: packet request carries the count of the write edge
    a_r3_pkt_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_en && pkt_ev && !ovf_ev) |=> (ts_valid && ts_reason == 2'b00 && ts_count == $past(cnt)));

    // R7: overflow wins and reports the maximum
    a_r7_ovf_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_en && ovf_ev) |=> (ts_valid && ts_reason == 2'b01 && ts_count == MAXV));

endmodule

// File: tb/delta_ts_gen_test.sv
module delta_ts_gen_test;

    localparam int PERIOD = 10;
    localparam int CW     = 6;
    localparam int MAXC   = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] ps = 2'b00;
    logic pkt = 1'b0;
    logic rdy = 1'b0;

    logic          v [2];
    logic [CW-1:0] c [2];
    logic [1:0]    r [2];

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    int idle_lim [2] = '{12, 100};
    int m_st [2], m_div [2], m_cnt [2], m_idl [2], m_pc [2], m_pr [2];

    always #(PERIOD/2) clk = ~clk;

    delta_ts_gen #(.CNT_W(CW), .IDLE_TICKS(12)) uut (
        .clk(clk), .rst_n(rst_n), .ts_en(en), .ps_sel(ps), .pkt_wr(pkt),
        .ts_ready(rdy), .ts_valid(v[0]), .ts_count(c[0]), .ts_reason(r[0])
    );

    delta_ts_gen #(.CNT_W(CW), .IDLE_TICKS(100)) uut_b (
        .clk(clk), .rst_n(rst_n), .ts_en(en), .ps_sel(ps), .pkt_wr(pkt),
        .ts_ready(rdy), .ts_valid(v[1]), .ts_count(c[1]), .ts_reason(r[1])
    );

    // behavioural reference, one step per rising edge
    task automatic model_step(input int k);
        int  lim;
        bit  act, tk, acc, ovf, pk, id;
        lim = 1 << (2 * ps);
        if (!en) begin
            m_st[k] = 0; m_div[k] = 0; m_cnt[k] = 0; m_idl[k] = 0;
        end else if (m_st[k] == 0) begin
            m_st[k] = 1;
        end else begin
            act = 1'b1;
            tk  = act && (m_div[k] >= lim - 1);
            acc = (m_st[k] == 2) && rdy;
            ovf = (m_st[k] == 1) && tk && (m_cnt[k] == MAXC);
            pk  = (m_st[k] == 1) && pkt && (m_cnt[k] != 0);
            id  = (m_st[k] == 1) && (m_idl[k] == idle_lim[k]);
            if (ovf)     begin m_pc[k] = MAXC;     m_pr[k] = 1; end
            else if (pk) begin m_pc[k] = m_cnt[k]; m_pr[k] = 0; end
            else if (id) begin m_pc[k] = m_cnt[k]; m_pr[k] = 2; end
            if (acc || pkt)                          m_idl[k] = 0;
            else if (tk && m_idl[k] < idle_lim[k])   m_idl[k] = m_idl[k] + 1;
            if (acc) m_cnt[k] = 0;
            else if (tk) begin
                if (m_cnt[k] == MAXC) m_cnt[k] = (m_st[k] == 1) ? 0 : MAXC;
                else                  m_cnt[k] = m_cnt[k] + 1;
            end
            m_div[k] = tk ? 0 : m_div[k] + 1;
            if (m_st[k] == 1 && (ovf || pk || id)) m_st[k] = 2;
            else if (acc)                          m_st[k] = 1;
        end
    endtask

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_st[k] = 0; m_div[k] = 0; m_cnt[k] = 0; m_idl[k] = 0;
                m_pc[k] = 0; m_pr[k] = 0;
            end else begin
                model_step(k);
            end
        end
    end

    task automatic compare();
        for (int k = 0; k < 2; k++) begin
            bit ev;
            ev = (m_st[k] == 2);
            n_chk++;
            if (v[k] !== ev || (ev && (c[k] !== CW'(m_pc[k]) || r[k] !== 2'(m_pr[k])))) begin
                n_bad++;
                $display("FAIL %s inst%0d valid/count/reason act=%0d/%0d/%0d exp=%0d/%0d/%0d",
                         tag, k, v[k], c[k], r[k], ev, m_pc[k], m_pr[k]);
            end
        end
    endtask

    task automatic step(input logic e, input logic [1:0] p, input logic k, input logic y);
        en = e; ps = p; pkt = k; rdy = y;
        @(negedge clk);
        compare();
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    bit done = 1'b0;

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset and disabled state
        tag = "R1";
        @(negedge clk); compare();
        @(negedge clk); compare();
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 1'b0, 1'b1);

        // R6 on the short-idle copy, R5 on the long-idle copy
        tag = "R6";
        for (int i = 0; i < 90; i++) step(1'b1, 2'b00, 1'b0, 1'b1);
        tag = "R5";
        for (int i = 0; i < 90; i++) step(1'b1, 2'b00, 1'b0, 1'b1);

        // R10 then R4: re-arm, packet with count still zero
        tag = "R10";
        step(1'b0, 2'b00, 1'b0, 1'b1);
        step(1'b1, 2'b00, 1'b0, 1'b1);
        tag = "R4";
        step(1'b1, 2'b00, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 2'b00, 1'b0, 1'b1);

        // R3 / R9: regular packets, immediate acceptance
        tag = "R3";
        for (int i = 0; i < 40; i++) step(1'b1, 2'b00, (i % 5) == 4, 1'b1);
        tag = "R9";
        for (int i = 0; i < 40; i++) step(1'b1, 2'b00, (i % 3) == 0, 1'b1);

        // R8: back-pressure with events and a long hold for saturation
        tag = "R8";
        for (int i = 0; i < 120; i++) step(1'b1, 2'b00, (i % 4) == 1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 2'b00, 1'b0, 1'b1);

        // R2: all prescale codes and mid-stream changes
        tag = "R2";
        for (int i = 0; i < 60; i++)   step(1'b1, 2'b01, (i % 9) == 8, 1'b1);
        for (int i = 0; i < 300; i++)  step(1'b1, 2'b10, (i % 37) == 36, 1'b1);
        for (int i = 0; i < 5000; i++) step(1'b1, 2'b11, 1'b0, 1'b1);
        for (int i = 0; i < 50; i++)   step(1'b1, 2'b00, 1'b0, 1'b1);

        // R10: drop enable with a request outstanding
        tag = "R10";
        for (int i = 0; i < 20; i++) step(1'b1, 2'b00, (i == 10), 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b0);
        step(1'b1, 2'b00, 1'b0, 1'b1);

        // R7: long mixed stream, packets land on overflow edges at times
        tag = "R7";
        for (int i = 0; i < 20000; i++) begin
            logic [1:0] pp;
            seed = nxt(seed);
            pp = (seed[31:24] < 8'd12) ? seed[5:4] : ps;
            step(seed[23:16] != 8'd0, pp, seed[9:8] == 2'b00, seed[13:12] != 2'b00);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule